// File: doc/BRIEF.md
# Host-to-DSP Software Interrupt Channel

This block passes a software interrupt from a host processor to a DSP. The host writes one byte to a message address. The block latches that byte and sets a busy flag that the host can poll. It also raises a pending status toward the DSP. The status reaches the DSP interrupt line through a mask bit that the DSP controls. Masking hides the interrupt but never discards it.

The two sides of the handshake are released separately. When the DSP reads the message byte, the pending status clears. The busy flag stays set until the DSP writes to its configuration register to release it. While busy is set, any further host message is dropped and a sticky lost flag records the drop. A parameter word of two bytes travels beside the message. The host writes it one byte at a time, and the DSP reads it as a single word, normally after it takes the interrupt.

Top module: `h2d_softirq`

## Requirements
- R1: After reset, busy, pending and lost are 0, the mask is enabled, `dsp_irq` is low and the parameter word is 0000h, so the DSP status word reads 0002h.
- R2: A host write to host address 50h while busy is 0 does three things, visible from the next cycle: it latches the byte, it sets busy, and it sets pending. A host read of 50h returns busy in bit 0 and zeros in the other bits.
- R3: `dsp_irq` is high exactly when pending and mask are both 1. A DSP write to 3074h loads the mask from bit 1. Clearing the mask leaves pending unchanged, so unmasking raises `dsp_irq` again.
- R4: A DSP read of 3050h returns the latched byte in bits 7:0 and clears pending. Busy is left unchanged.
- R5: Once set, busy stays 1 until a DSP write to 3074h has bit 3 equal to 0. A DSP write with bit 3 equal to 1 leaves busy as it is.
- R6: A host write to 50h while busy is 1 is dropped. The byte and pending are unchanged, and a sticky lost flag is set. A DSP write to 3074h with bit 2 equal to 1 clears the lost flag.
- R7: Host writes to 60h and 61h load the low and high bytes of the parameter word. The host reads each byte back at the same address. The DSP reads the whole word at 3060h.
- R8: A host message accepted in the same cycle as a DSP read of 3050h keeps pending set, and the read returns the previous byte. A host message arriving in the same cycle as a busy release is still dropped, because the acceptance test uses the busy value before that edge.
- R9: The DSP status word at 3074h reads pending in bit 0, mask in bit 1, lost in bit 2 and busy in bit 3, with zeros in the other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe |
| host_addr | input | HA_W | Host register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational on `host_addr` |
| dsp_we | input | 1 | DSP write strobe |
| dsp_re | input | 1 | DSP read strobe; a read of the message address clears pending |
| dsp_addr | input | DA_W | DSP register address |
| dsp_wdata | input | 16 | DSP write word |
| dsp_rdata | output | 16 | DSP read word, combinational on `dsp_addr` |
| dsp_irq | output | 1 | Masked interrupt toward the DSP |

## Verification
The normal handshake is driven with a table of byte and word values. The table includes all zeros, all ones and alternating bit patterns, so that swapped lanes and stuck bits in the message path and in both halves of the parameter word show up. Directed sequences then separate the two releases from each other. One releases busy without reading the message, and another reads the message without releasing busy. Further directed tests mask and unmask the line while an interrupt is pending. They also send messages while busy is set to exercise the lost flag and its clear. Two same-cycle collisions check which update wins.

// File: rtl/h2d_pkg.sv
package h2d_pkg;

    localparam int unsigned MSG_W = 8;

    // Bit positions in the DSP status/configuration word
    localparam int unsigned ST_PEND = 0;
    localparam int unsigned ST_MASK = 1;
    localparam int unsigned ST_LOST = 2;
    localparam int unsigned ST_BUSY = 3;
    localparam int unsigned ST_BITS = 4;

    typedef struct packed {
        logic             busy;
        logic             pend;
        logic             mask_en;
        logic             lost;
        logic [MSG_W-1:0] msg;
    } flag_state_t;

    localparam flag_state_t FLAG_RESET = '{
        busy:    1'b0,
        pend:    1'b0,
        mask_en: 1'b1,
        lost:    1'b0,
        msg:     '0
    };

endpackage

// File: rtl/h2d_host_port.sv
module h2d_host_port #(
    parameter int unsigned     HA_W      = 8,
    parameter int unsigned     NB        = 2,
    parameter logic [HA_W-1:0] MSG_ADDR  = 8'h50,
    parameter logic [HA_W-1:0] CTRL_BASE = 8'h60
) (
    input  logic                 host_we,
    input  logic [HA_W-1:0]      host_addr,
    input  logic                 busy,
    input  logic [NB-1:0][7:0]   ctrl_word,
    output logic                 msg_wr,
    output logic [NB-1:0]        ctrl_be,
    output logic [7:0]           host_rdata
);

    logic [NB-1:0] lane_hit;

    assign msg_wr = host_we && (host_addr == MSG_ADDR);

    for (genvar gi = 0; gi < NB; gi++) begin : g_lane
        localparam logic [HA_W-1:0] LANE_ADDR = HA_W'(int'(CTRL_BASE) + gi);
        assign lane_hit[gi] = (host_addr == LANE_ADDR);
        assign ctrl_be[gi]  = host_we && lane_hit[gi];
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == MSG_ADDR) begin
            host_rdata = {7'b0, busy};
        end
        for (int i = 0; i < NB; i++) begin
            if (lane_hit[i]) begin
                host_rdata = ctrl_word[i];
            end
        end
    end

endmodule

// File: rtl/h2d_ctrl_reg.sv
module h2d_ctrl_reg #(
    parameter int unsigned NB = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NB-1:0]      be,
    input  logic [7:0]         wbyte,
    output logic [NB-1:0][7:0] word
);

    logic [NB-1:0][7:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        for (int i = 0; i < NB; i++) begin
            if (be[i]) begin
                word_d[i] = wbyte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;

    for (genvar gi = 0; gi < NB; gi++) begin : g_chk
        // R7: a byte write lands in its own lane only
        p_lane_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
            be[gi] |=> word_q[gi] == $past(wbyte));
        p_lane_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !be[gi] |=> $stable(word_q[gi]));
    end

endmodule

// File: rtl/h2d_flag_core.sv
module h2d_flag_core
    import h2d_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_wr,
    input  logic [MSG_W-1:0] msg_byte,
    input  logic             msg_rd,
    input  logic             cfg_wr,
    input  logic             cfg_mask,
    input  logic             cfg_keep_busy,
    input  logic             cfg_lost_clr,
    output flag_state_t      st
);

    flag_state_t st_d, st_q;
    logic        accept, drop;

    assign accept = msg_wr && !st_q.busy;
    assign drop   = msg_wr &&  st_q.busy;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.mask_en = cfg_mask;
            if (!cfg_keep_busy) st_d.busy = 1'b0;
            if (cfg_lost_clr)   st_d.lost = 1'b0;
        end
        if (msg_rd) begin
            st_d.pend = 1'b0;
        end
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.pend = 1'b1;
            st_d.msg  = msg_byte;
        end
        if (drop) begin
            st_d.lost = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FLAG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    // R2: accepted message sets busy, pending and the byte
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> st_q.busy && st_q.pend && st_q.msg == $past(msg_byte));
    // R5: busy holds until an explicit release
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !(cfg_wr && !cfg_keep_busy)) |=> st_q.busy);
    p_busy_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_keep_busy && !accept) |=> !st_q.busy);
    // R4: message read clears pending
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_rd && !accept) |=> !st_q.pend);
    // R3: mask never clears pending
    p_mask_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !msg_rd) |=> st_q.pend);
    // R6: dropped message keeps the byte and marks lost
    p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> st_q.lost && $stable(st_q.msg));
    // R8: new message wins over a same-cycle read
    p_race_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && msg_rd) |=> st_q.pend);

endmodule

// File: rtl/h2d_softirq.sv
module h2d_softirq
    import h2d_pkg::*;
#(
    parameter int unsigned     HA_W          = 8,
    parameter int unsigned     DA_W          = 16,
    parameter int unsigned     CTRL_BYTES    = 2,
    parameter logic [HA_W-1:0] HOST_MSG_ADDR = 8'h50,
    parameter logic [HA_W-1:0] HOST_CTRL     = 8'h60,
    parameter logic [DA_W-1:0] DSP_MSG_ADDR  = 16'h3050,
    parameter logic [DA_W-1:0] DSP_CTRL_ADDR = 16'h3060,
    parameter logic [DA_W-1:0] DSP_STAT_ADDR = 16'h3074
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_we,
    input  logic [HA_W-1:0] host_addr,
    input  logic [7:0]      host_wdata,
    output logic [7:0]      host_rdata,
    input  logic            dsp_we,
    input  logic            dsp_re,
    input  logic [DA_W-1:0] dsp_addr,
    input  logic [15:0]     dsp_wdata,
    output logic [15:0]     dsp_rdata,
    output logic            dsp_irq
);

    localparam int unsigned CTRL_W = 8 * CTRL_BYTES;

    flag_state_t                 st;
    logic                        msg_wr;
    logic [CTRL_BYTES-1:0]       ctrl_be;
    logic [CTRL_BYTES-1:0][7:0]  ctrl_word;
    logic                        dsp_msg_rd, dsp_cfg_wr;
    logic [ST_BITS-1:0]          stat_word;
    logic                        unused_wbits;

    assign unused_wbits = ^{dsp_wdata[15:ST_BITS], dsp_wdata[ST_PEND]};

    h2d_host_port #(
        .HA_W      (HA_W),
        .NB        (CTRL_BYTES),
        .MSG_ADDR  (HOST_MSG_ADDR),
        .CTRL_BASE (HOST_CTRL)
    ) u_host (
        .host_we    (host_we),
        .host_addr  (host_addr),
        .busy       (st.busy),
        .ctrl_word  (ctrl_word),
        .msg_wr     (msg_wr),
        .ctrl_be    (ctrl_be),
        .host_rdata (host_rdata)
    );

    h2d_ctrl_reg #(
        .NB (CTRL_BYTES)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .be    (ctrl_be),
        .wbyte (host_wdata),
        .word  (ctrl_word)
    );

    assign dsp_msg_rd = dsp_re && (dsp_addr == DSP_MSG_ADDR);
    assign dsp_cfg_wr = dsp_we && (dsp_addr == DSP_STAT_ADDR);

    h2d_flag_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .msg_wr        (msg_wr),
        .msg_byte      (host_wdata),
        .msg_rd        (dsp_msg_rd),
        .cfg_wr        (dsp_cfg_wr),
        .cfg_mask      (dsp_wdata[ST_MASK]),
        .cfg_keep_busy (dsp_wdata[ST_BUSY]),
        .cfg_lost_clr  (dsp_wdata[ST_LOST]),
        .st            (st)
    );

    always_comb begin
        stat_word          = '0;
        stat_word[ST_PEND] = st.pend;
        stat_word[ST_MASK] = st.mask_en;
        stat_word[ST_LOST] = st.lost;
        stat_word[ST_BUSY] = st.busy;
    end

    always_comb begin
        dsp_rdata = '0;
        if (dsp_addr == DSP_MSG_ADDR) begin
            dsp_rdata = 16'(st.msg);
        end else if (dsp_addr == DSP_CTRL_ADDR) begin
            dsp_rdata = 16'(CTRL_W'(ctrl_word));
        end else if (dsp_addr == DSP_STAT_ADDR) begin
            dsp_rdata = 16'(stat_word);
        end
    end

    assign dsp_irq = st.pend && st.mask_en;

    // R3: interrupt line follows pending while unmasked
    p_irq_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st.mask_en && st.pend) |-> dsp_irq);
    // R3: masked line stays low whatever pending does
    p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st.mask_en |-> !dsp_irq);
    // R2: host sees busy from the cycle after an accepted message
    p_host_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_wr && !st.busy) |=> st.busy);

endmodule

// File: tb/h2d_softirq_tb.sv
module h2d_softirq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        dsp_we = 1'b0;
    logic        dsp_re = 1'b0;
    logic [15:0] dsp_addr = '0;
    logic [15:0] dsp_wdata = '0;
    logic [15:0] dsp_rdata;
    logic        dsp_irq;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    localparam logic [7:0]  H_MSG  = 8'h50;
    localparam logic [7:0]  H_CLO  = 8'h60;
    localparam logic [7:0]  H_CHI  = 8'h61;
    localparam logic [15:0] D_MSG  = 16'h3050;
    localparam logic [15:0] D_CTRL = 16'h3060;
    localparam logic [15:0] D_STAT = 16'h3074;

    // {message byte, parameter word}
    localparam logic [23:0] VEC [8] = '{
        24'h00_0000, 24'hFF_FFFF, 24'hA5_5AA5, 24'h5A_A55A,
        24'h01_8001, 24'h80_0180, 24'h7E_1234, 24'h3C_FEDC
    };

    always #4 clk = ~clk;

    h2d_softirq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .dsp_we     (dsp_we),
        .dsp_re     (dsp_re),
        .dsp_addr   (dsp_addr),
        .dsp_wdata  (dsp_wdata),
        .dsp_rdata  (dsp_rdata),
        .dsp_irq    (dsp_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic dsp_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        dsp_we = 1'b1; dsp_addr = a; dsp_wdata = d;
        @(negedge clk);
        dsp_we = 1'b0;
    endtask

    task automatic dsp_rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        dsp_re = 1'b1; dsp_addr = a;
        #1;
        d = dsp_rdata;
        @(negedge clk);
        dsp_re = 1'b0;
    endtask

    // host message write together with one DSP access in the same cycle
    task automatic collide(input logic [7:0] hd, input logic dwe, input logic dre,
                           input logic [15:0] da, input logic [15:0] dd,
                           output logic [15:0] rd);
        @(negedge clk);
        host_we = 1'b1; host_addr = H_MSG; host_wdata = hd;
        dsp_we = dwe; dsp_re = dre; dsp_addr = da; dsp_wdata = dd;
        #1;
        rd = dsp_rdata;
        @(negedge clk);
        host_we = 1'b0; dsp_we = 1'b0; dsp_re = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  hb;
        logic [15:0] dw;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq low", 16'(dsp_irq), 16'h0);
        host_rd(H_MSG, hb); chk("R1 busy clear", 16'(hb), 16'h0);
        dsp_rd(D_STAT, dw); chk("R1 R9 status word", dw, 16'h0002);
        dsp_rd(D_CTRL, dw); chk("R1 parameter word", dw, 16'h0000);

        // table-driven handshake
        for (int i = 0; i < 8; i++) begin
            host_wr(H_CLO, VEC[i][7:0]);
            host_wr(H_CHI, VEC[i][15:8]);
            host_wr(H_MSG, VEC[i][23:16]);
            host_rd(H_MSG, hb); chk("R2 host busy", 16'(hb), 16'h1);
            chk("R3 irq raised", 16'(dsp_irq), 16'h1);
            dsp_rd(D_STAT, dw); chk("R9 status after message", dw, 16'h000B);
            dsp_rd(D_CTRL, dw); chk("R7 DSP word", dw, VEC[i][15:0]);
            host_rd(H_CLO, hb); chk("R7 host low byte", 16'(hb), 16'(VEC[i][7:0]));
            host_rd(H_CHI, hb); chk("R7 host high byte", 16'(hb), 16'(VEC[i][15:8]));
            dsp_rd(D_MSG, dw); chk("R4 message byte", dw, 16'(VEC[i][23:16]));
            chk("R4 irq cleared by read", 16'(dsp_irq), 16'h0);
            host_rd(H_MSG, hb); chk("R5 busy kept after read", 16'(hb), 16'h1);
            dsp_wr(D_STAT, 16'h0002);
            host_rd(H_MSG, hb); chk("R5 busy released", 16'(hb), 16'h0);
        end

        // R5 and R6: write with keep-busy, then a dropped message
        host_wr(H_MSG, 8'h11);
        dsp_wr(D_STAT, 16'h000A);
        host_rd(H_MSG, hb); chk("R5 keep-busy write", 16'(hb), 16'h1);
        host_wr(H_MSG, 8'h22);
        dsp_rd(D_STAT, dw); chk("R6 lost set", dw, 16'h000F);
        dsp_rd(D_MSG, dw); chk("R6 byte kept", dw, 16'h0011);
        dsp_wr(D_STAT, 16'h000E);
        dsp_rd(D_STAT, dw); chk("R6 lost cleared", dw, 16'h000A);

        // R3: masking hides but keeps pending
        dsp_wr(D_STAT, 16'h0006);
        host_wr(H_MSG, 8'h33);
        chk("R3 irq up", 16'(dsp_irq), 16'h1);
        dsp_wr(D_STAT, 16'h0008);
        chk("R3 irq masked", 16'(dsp_irq), 16'h0);
        dsp_rd(D_STAT, dw); chk("R3 pending kept under mask", dw, 16'h0009);
        dsp_wr(D_STAT, 16'h000A);
        chk("R3 irq after unmask", 16'(dsp_irq), 16'h1);

        // R8: accepted message with same-cycle read
        dsp_wr(D_STAT, 16'h0002);
        collide(8'h44, 1'b0, 1'b1, D_MSG, 16'h0000, dw);
        chk("R8 read returns old byte", dw, 16'h0033);
        chk("R8 pending kept", 16'(dsp_irq), 16'h1);
        dsp_rd(D_MSG, dw); chk("R8 new byte", dw, 16'h0044);

        // R8: message colliding with busy release is dropped
        collide(8'h55, 1'b1, 1'b0, D_STAT, 16'h0002, dw);
        dsp_rd(D_STAT, dw); chk("R8 drop on release edge", dw, 16'h0006);
        dsp_rd(D_MSG, dw); chk("R8 byte unchanged", dw, 16'h0044);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule